// File: doc/BRIEF.md
# Six-Step Inverter Gate Sequencer

This block produces the six gate-drive signals of a three-phase bridge inverter run in 180-degree conduction. It counts system clocks down to a programmable time slice, groups ten slices into one step, and walks a six-state step counter. Each step index is decoded into a six-bit gate pattern in which three switches conduct. A fixed share of each step, its first slice, is blanked so that every gate is low while the switches of a leg hand over, which gives the dead time.

The fundamental output frequency is the step rate divided by six. With a 10 MHz system clock, ratios of 1000, 500 and 200 give step rates of 1 kHz, 2 kHz and 5 kHz, and so fundamentals near 166.7 Hz, 333.3 Hz and 833.3 Hz. The ratio input is taken only while the block is idle or when the step counter wraps to zero, so a change never cuts a step short. Gate and step outputs are registered, so they cannot glitch.

Top module: `six_step_gate_seq`

## Requirements
- R1: While rst_n is low, and on the first clock edge at which en is sampled low, gate and step_idx go to zero and all internal counters clear.
- R2: step_idx runs 0,1,2,3,4,5 and then back to 0; it never shows 6 or 7, and it only ever moves up by one or wraps from 5 to 0.
- R3: With an effective ratio E, one slice lasts E clocks and one step lasts 10*E clocks; after en is sampled high at edge 1, the outputs after edge n show slice s = floor((n-1)/E) mod 10 of step floor((n-1)/(10*E)) mod 6.
- R4: Outside the dead window, gate (bit 0 = switch 1, bit 5 = switch 6) shows 6'b110001, 6'b100011, 6'b000111, 6'b001110, 6'b011100, 6'b111000 in steps 0 to 5, so switch k conducts in steps k-1, k and k+1 modulo 6 and the three phases are two steps (120 degrees) apart.
- R5: Whenever any gate is high, exactly three gates are high.
- R6: The leg pairs (switches 1 and 4, 3 and 6, 5 and 2, that is bits 0/3, 2/5, 4/1) are never high together.
- R7: All gates are low during slice 0 of every step, which is the first tenth of the step; in particular gate is zero in any cycle where step_idx has just changed.
- R8: ratio is captured while en is low and at the edge where step 5 ends; a change made in mid-cycle takes effect from the next step 0.
- R9: A ratio value of 0 acts as 1.
- R10: The first step after en rises begins with its dead window, and the outputs follow the counters by one registered clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| en | input | 1 | Run enable; low holds outputs low and clears counters |
| ratio | input | 16 | System clocks per slice; a step is ten slices |
| gate | output | 6 | Active-high gate drives, bit 0 = switch 1 |
| step_idx | output | 3 | Current step, 0 to 5 |

## Verification
On every cycle the checker confirms the safety properties of the outputs: no leg pair conducts together, three gates are high whenever any are, the step index stays in range and only climbs by one or wraps, every step change lands in a dead window, and a low enable clears the outputs one clock later. The exact pattern per step, the slice and step durations for each ratio, the treatment of a zero ratio, and the deferred take-up of a ratio change at the cycle wrap depend on counting clocks across whole cycles, so only the bench's scenarios can show them.

// File: rtl/six_step_pkg.sv
package six_step_pkg;

  localparam int STEPS  = 6;
  localparam int GATES  = 6;
  localparam int STEP_W = 3;

  typedef logic [STEP_W-1:0] step_t;
  typedef logic [GATES-1:0]  gate_t;

  localparam step_t LAST_STEP = step_t'(STEPS - 1);
  localparam step_t WRAP_CODE = step_t'(STEPS);

  // Switch i (0-based) conducts for three consecutive steps starting at step i.
  function automatic gate_t gate_pattern(input step_t s);
    gate_t pat;
    for (int i = 0; i < GATES; i++) begin
      int d;
      d = (int'(s) + STEPS - i) % STEPS;
      pat[i] = (d < 3);
    end
    return pat;
  endfunction

endpackage

// File: rtl/sss_prescaler.sv
module sss_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             tick
);

  logic [DIV_W-1:0] ratio_q, ratio_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] ratio_eff;

  always_comb begin
    ratio_eff = (ratio_q == '0) ? DIV_W'(1) : ratio_q;
    tick      = !clr && (cnt_q == ratio_eff - DIV_W'(1));
  end

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
    if (clr || load) ratio_d = ratio_in;
    else             ratio_d = ratio_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end

endmodule

// File: rtl/sss_slice_ctr.sv
module sss_slice_ctr #(
  parameter int SLICES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic wrap,
  output logic active
);

  localparam int SLICE_W = $clog2(SLICES);
  localparam logic [SLICE_W-1:0] LAST = SLICE_W'(SLICES - 1);

  logic [SLICE_W-1:0] slice_q, slice_d;

  always_comb begin
    wrap   = tick && (slice_q == LAST);
    active = |slice_q;
    if (clr)       slice_d = '0;
    else if (wrap) slice_d = '0;
    else if (tick) slice_d = slice_q + SLICE_W'(1);
    else           slice_d = slice_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slice_q <= '0;
    else        slice_q <= slice_d;
  end

endmodule

// File: rtl/sss_step_ctr.sv
module sss_step_ctr
  import six_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  adv,
  output step_t step,
  output logic  cycle_end
);

  step_t step_q, step_d, step_inc;

  always_comb begin
    step_inc  = step_q + step_t'(1);
    cycle_end = adv && (step_q == LAST_STEP);
    if (clr)      step_d = '0;
    else if (adv) step_d = (step_inc == WRAP_CODE) ? step_t'(0) : step_inc;
    else          step_d = step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/sss_gate_out.sv
module sss_gate_out
  import six_step_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  active,
  input  step_t step,
  output gate_t gate,
  output step_t step_out
);

  gate_t gate_q, gate_d;
  step_t idx_q, idx_d;

  always_comb begin
    gate_d = (en && active) ? gate_pattern(step) : '0;
    idx_d  = en ? step : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      idx_q  <= '0;
    end else begin
      gate_q <= gate_d;
      idx_q  <= idx_d;
    end
  end

  assign gate     = gate_q;
  assign step_out = idx_q;

endmodule

// File: rtl/six_step_gate_seq.sv
module six_step_gate_seq
  import six_step_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int SLICES = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] ratio,
  output logic [5:0]       gate,
  output logic [2:0]       step_idx
);

  logic  clr, tick, slice_wrap, slice_active, cycle_end;
  step_t step_cur;

  assign clr = !en;

  sss_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load     (cycle_end),
    .ratio_in (ratio),
    .tick     (tick)
  );

  sss_slice_ctr #(.SLICES(SLICES)) u_slice (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .tick   (tick),
    .wrap   (slice_wrap),
    .active (slice_active)
  );

  sss_step_ctr u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .adv       (slice_wrap),
    .step      (step_cur),
    .cycle_end (cycle_end)
  );

  sss_gate_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .active   (slice_active),
    .step     (step_cur),
    .gate     (gate),
    .step_out (step_idx)
  );

endmodule

// File: rtl/six_step_gate_seq_chk.sv
module six_step_gate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [5:0] gate,
  input logic [2:0] step_idx
);

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate == 6'd0 && step_idx == 3'd0));

  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx < 3'd6);

  assert_step_climb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx != $past(step_idx) && step_idx != 3'd0) |-> step_idx == $past(step_idx) + 3'd1);

  assert_three_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate != 6'd0) |-> ($countones(gate) == 3));

  assert_leg_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate[0] && gate[3]) && !(gate[2] && gate[5]) && !(gate[4] && gate[1]));

  assert_dead_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx != $past(step_idx)) |-> (gate == 6'd0));

endmodule

bind six_step_gate_seq six_step_gate_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .gate     (gate),
  .step_idx (step_idx)
);

// File: tb/sim_six_step_gate_seq.sv
`timescale 1ns/1ps
module sim_six_step_gate_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [15:0] ratio;
  logic [5:0]  gate;
  logic [2:0]  step_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // expected gate vector per step, bit 0 = switch 1
  localparam logic [5:0] PAT [6] = '{6'b110001, 6'b100011, 6'b000111,
                                     6'b001110, 6'b011100, 6'b111000};
  // ratio under test; 0 must behave as 1
  localparam logic [15:0] RUNS [5] = '{16'd1, 16'd2, 16'd3, 16'd5, 16'd0};

  always #2.5 clk = ~clk;

  six_step_gate_seq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .ratio(ratio),
    .gate(gate), .step_idx(step_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int t_chg [8];
    int nchg;
    int clk_n;
    logic [2:0] prev;

    rst_n = 1'b0; en = 1'b0; ratio = 16'd2;
    #1;
    chk("R1 gate in reset", gate, 0);
    chk("R1 step in reset", step_idx, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // vector walk over ratios
    foreach (RUNS[k]) begin
      int eff;
      eff = (RUNS[k] == 16'd0) ? 1 : int'(RUNS[k]);
      en = 1'b0; ratio = RUNS[k];
      @(negedge clk) en = 1'b1;
      for (int n = 1; n <= 120 * eff + 5; n++) begin
        int s, sub, stp;
        @(posedge clk); #1;
        s = (n - 1) / eff; sub = s % 10; stp = (s / 10) % 6;
        if (RUNS[k] == 16'd0) begin
          chk("R9 gate", gate, (sub == 0) ? 0 : PAT[stp]);
          chk("R9 step", step_idx, stp);
        end else if (n <= eff + 1) begin
          chk("R10 first dead window", gate, (sub == 0) ? 0 : PAT[stp]);
          chk("R3 step", step_idx, stp);
        end else begin
          chk(sub == 0 ? "R7 dead gate" : "R4 gate", gate, (sub == 0) ? 0 : PAT[stp]);
          chk("R3 step", step_idx, stp);
        end
        if (gate != 6'd0) chk("R5 count", $countones(gate), 3);
        chk("R6 pairs", int'((gate[0] & gate[3]) | (gate[2] & gate[5]) | (gate[4] & gate[1])), 0);
      end
      @(negedge clk);
    end

    // disable mid-run
    en = 1'b0; ratio = 16'd2;
    @(negedge clk) en = 1'b1;
    repeat (47) @(negedge clk);
    en = 1'b0;
    @(posedge clk); #1;
    chk("R1 gate after disable", gate, 0);
    chk("R1 step after disable", step_idx, 0);

    // ratio change in mid-cycle takes effect at next step 0
    @(negedge clk) ratio = 16'd2;
    @(negedge clk) en = 1'b1;
    @(negedge clk) ratio = 16'd4;
    nchg = 0; clk_n = 0; prev = step_idx;
    while (nchg < 7 && clk_n < 2000) begin
      @(posedge clk); #1;
      clk_n++;
      if (step_idx != prev) begin
        t_chg[nchg] = clk_n;
        nchg++;
        prev = step_idx;
      end
    end
    chk("R8 changes seen", nchg, 7);
    for (int i = 0; i < 5; i++) chk("R8 old ratio step length", t_chg[i+1] - t_chg[i], 20);
    chk("R8 new ratio step length", t_chg[6] - t_chg[5], 40);
    chk("R2 wrap then step", step_idx, 1);

    // asynchronous reset in mid-run
    #1.2 rst_n = 1'b0;
    #0.5;
    chk("R1 gate async reset", gate, 0);
    chk("R1 step async reset", step_idx, 0);
    @(negedge clk) rst_n = 1'b1;
    en = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule